// File: doc/BRIEF.md
# I2C Controller FIFO Occupancy and Status Tracker

This block holds the transmit and receive byte queues of an I2C controller and keeps software informed of their state. The host writes bytes into the transmit queue and the serial engine drains them. The serial engine fills the receive queue and the host empties it. Each queue keeps a live entry count. Three registered status flags are derived from those counts. Both queues are emptied when the controller is switched off or a transmit abort fires. An abort of slave bulk transfer empties only the transmit queue.

A sticky abort-cause register gathers one bit per abort reason. It is cleared either by reading it over the register bus or by a global interrupt clear. All register reads are strobe-based. The read data appears on the cycle after the strobe. The block's asynchronous active-low reset is released through a two-stage synchronizer inside the block.

Top module: `i2c_fifo_tracker`

## Requirements
- R1: Each queue's level register counts valid entries from 0 to 8. It rises by one on an accepted write and falls by one on an accepted take. The level sits in bits [3:0] of its register, and bits [31:4] read as zero.
- R2: After reset, both levels read 0 and the abort-cause register reads 0. The status register reads 4'b0110: receive-not-empty is 0, transmit-empty is 1, transmit-not-full is 1, and bit 0 is 0.
- R3: While `ctrl_en_i` is low, or in any cycle where `tx_abort_i` is high, both queues are emptied at the next edge. This flush overrides a write or take in the same cycle.
- R4: A high `slv_bulk_abort_i` empties the transmit queue at the next edge and leaves the receive queue and its level untouched.
- R5: Status bit 3 (receive-not-empty) is 1 exactly when the receive level was non-zero one cycle earlier.
- R6: Status bit 2 (transmit-empty) is 1 exactly when the transmit level was zero one cycle earlier.
- R7: Status bit 1 (transmit-not-full) is 1 exactly when the transmit level was below 8 one cycle earlier.
- R8: A write into a full queue with no take in the same cycle is ignored. A take from an empty queue is ignored. Neither changes the level or the stored data.
- R9: Queues are first-in first-out. A write and a take in the same cycle on a non-empty queue leave the level unchanged, and this includes a full queue.
- R10: A cycle with `tx_abort_i` high ORs `abrt_cause_i` into the abort-cause register. A read of offset 0x0C returns the held value and clears the register. `intr_clr_all_i` also clears it. A clear wins over a set in the same cycle.
- R11: A read strobe returns data on the next cycle. The offsets are 0x00 for status, 0x04 for transmit level, 0x08 for receive level and 0x0C for abort cause. Any other offset, and any cycle without a strobe, gives zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_en_i | input | 1 | Controller enable; low flushes both queues |
| tx_abort_i | input | 1 | Transmit abort event |
| abrt_cause_i | input | 16 | Abort reasons captured with `tx_abort_i` |
| slv_bulk_abort_i | input | 1 | Slave bulk transfer abort; flushes transmit only |
| intr_clr_all_i | input | 1 | Global interrupt clear |
| host_tx_push_i | input | 1 | Host writes a byte to the transmit queue |
| host_tx_data_i | input | 8 | Byte written by the host |
| host_rx_pop_i | input | 1 | Host takes a byte from the receive queue |
| host_rx_data_o | output | 8 | Head of the receive queue |
| eng_tx_pop_i | input | 1 | Serial engine takes a byte from the transmit queue |
| eng_tx_data_o | output | 8 | Head of the transmit queue |
| eng_rx_push_i | input | 1 | Serial engine writes a received byte |
| eng_rx_data_i | input | 8 | Byte written by the serial engine |
| reg_rd_en_i | input | 1 | Register read strobe |
| reg_addr_i | input | 8 | Register byte offset |
| reg_rdata_o | output | 32 | Registered read data |

## Verification
The hardest case is a write and a take landing together on a full queue, because it only arises after the queue has been driven to exactly 8 entries while the other side stays idle. The stimulus first fills the transmit queue past capacity, then holds both strobes high for several cycles. A second hard case is a clear and a set of the abort-cause register in the same cycle, along with a read-clear racing a fresh abort. Directed cycles raise `tx_abort_i` together with `intr_clr_all_i`, and then read offset 0x0C twice. Long randomised traffic with rare aborts and disables is then compared against a queue-based model on every clock.

// File: rtl/i2c_fst_pkg.sv
package i2c_fst_pkg;

  localparam int unsigned REG_AW = 8;
  localparam int unsigned REG_DW = 32;

  localparam logic [REG_AW-1:0] OFS_STATUS = 8'h00;
  localparam logic [REG_AW-1:0] OFS_TXLVL  = 8'h04;
  localparam logic [REG_AW-1:0] OFS_RXLVL  = 8'h08;
  localparam logic [REG_AW-1:0] OFS_ABRT   = 8'h0C;

  localparam int unsigned NUM_QUEUES = 2;
  localparam int unsigned Q_TX = 0;
  localparam int unsigned Q_RX = 1;

  typedef struct packed {
    logic rx_nempty;
    logic tx_empty;
    logic tx_nfull;
  } fst_flags_t;

endpackage

// File: rtl/i2c_fst_rst_sync.sv
module i2c_fst_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];

endmodule

// File: rtl/i2c_fst_fifo.sv
module i2c_fst_fifo #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned WIDTH = 8,
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned LW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] pop_data,
  output logic [LW-1:0]    level
);

  localparam logic [LW-1:0] LVL_FULL = LW'(DEPTH);
  localparam logic [AW-1:0] PTR_LAST = AW'(DEPTH - 1);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [AW-1:0]    wptr_q, wptr_d;
  logic [AW-1:0]    rptr_q, rptr_d;
  logic [LW-1:0]    lvl_q, lvl_d;
  logic             pop_ok, push_ok;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == PTR_LAST) ? '0 : p + AW'(1);
  endfunction

  always_comb begin
    pop_ok  = pop  && !flush && (lvl_q != '0);
    push_ok = push && !flush && ((lvl_q != LVL_FULL) || pop_ok);
  end

  always_comb begin
    lvl_d  = lvl_q;
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    if (flush) begin
      lvl_d  = '0;
      wptr_d = '0;
      rptr_d = '0;
    end else begin
      if (push_ok) wptr_d = ptr_inc(wptr_q);
      if (pop_ok)  rptr_d = ptr_inc(rptr_q);
      unique case ({push_ok, pop_ok})
        2'b10:   lvl_d = lvl_q + LW'(1);
        2'b01:   lvl_d = lvl_q - LW'(1);
        default: lvl_d = lvl_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q  <= '0;
      wptr_q <= '0;
      rptr_q <= '0;
    end else begin
      lvl_q  <= lvl_d;
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem_q[wptr_q] <= push_data;
  end

  assign pop_data = mem_q[rptr_q];
  assign level    = lvl_q;

  AST_LVL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_q <= LVL_FULL); // R1
  AST_LVL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !flush |=> (lvl_q == $past(lvl_q)) || (lvl_q == $past(lvl_q) + LW'(1))
               || (lvl_q + LW'(1) == $past(lvl_q))); // R1
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (lvl_q == '0)); // R3
  AST_FULL_PUSH_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush && push && !pop && lvl_q == LVL_FULL) |=> (lvl_q == LVL_FULL)); // R8
  AST_EMPTY_POP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush && pop && !push && lvl_q == '0) |=> (lvl_q == '0)); // R8
  AST_BOTH_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush && push && pop && lvl_q != '0) |=> $stable(lvl_q)); // R9

endmodule

// File: rtl/i2c_fst_flags.sv
module i2c_fst_flags
  import i2c_fst_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned LW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [LW-1:0] tx_lvl,
  input  logic [LW-1:0] rx_lvl,
  output fst_flags_t    flags
);

  fst_flags_t flags_q, flags_d;

  always_comb begin
    flags_d.rx_nempty = (rx_lvl != '0);
    flags_d.tx_empty  = (tx_lvl == '0);
    flags_d.tx_nfull  = (tx_lvl != LW'(DEPTH));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q.rx_nempty <= 1'b0;
      flags_q.tx_empty  <= 1'b1;
      flags_q.tx_nfull  <= 1'b1;
    end else begin
      flags_q <= flags_d;
    end
  end

  assign flags = flags_q;

  AST_RXNE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_lvl != '0) |=> flags_q.rx_nempty); // R5
  AST_TXE_EXCL_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    !(flags_q.tx_empty && !flags_q.tx_nfull)); // R6
  AST_TXNF_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_lvl == LW'(DEPTH)) |=> !flags_q.tx_nfull); // R7

endmodule

// File: rtl/i2c_fst_abrt.sv
module i2c_fst_abrt #(
  parameter int unsigned NCAUSE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_en,
  input  logic [NCAUSE-1:0] cause,
  input  logic              clr,
  output logic [NCAUSE-1:0] src
);

  logic [NCAUSE-1:0] src_q, src_d;

  always_comb begin
    src_d = src_q;
    if (clr)         src_d = '0;
    else if (set_en) src_d = src_q | cause;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) src_q <= '0;
    else        src_q <= src_d;
  end

  assign src = src_q;

  AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (src_q == '0)); // R10
  AST_BITS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((src_q & $past(src_q)) == $past(src_q))); // R10

endmodule

// File: rtl/i2c_fifo_tracker.sv
module i2c_fifo_tracker
  import i2c_fst_pkg::*;
#(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned NCAUSE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_en_i,
  input  logic              tx_abort_i,
  input  logic [NCAUSE-1:0] abrt_cause_i,
  input  logic              slv_bulk_abort_i,
  input  logic              intr_clr_all_i,
  input  logic              host_tx_push_i,
  input  logic [WIDTH-1:0]  host_tx_data_i,
  input  logic              host_rx_pop_i,
  output logic [WIDTH-1:0]  host_rx_data_o,
  input  logic              eng_tx_pop_i,
  output logic [WIDTH-1:0]  eng_tx_data_o,
  input  logic              eng_rx_push_i,
  input  logic [WIDTH-1:0]  eng_rx_data_i,
  input  logic              reg_rd_en_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  output logic [REG_DW-1:0] reg_rdata_o
);

  localparam int unsigned LW = $clog2(DEPTH + 1);

  logic rst_n_int;

  i2c_fst_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  logic [NUM_QUEUES-1:0] q_push, q_pop, q_flush;
  logic [WIDTH-1:0]      q_wdata [NUM_QUEUES];
  logic [WIDTH-1:0]      q_rdata [NUM_QUEUES];
  logic [LW-1:0]         q_lvl   [NUM_QUEUES];
  logic                  flush_all;

  assign flush_all = !ctrl_en_i || tx_abort_i;

  assign q_push[Q_TX]  = host_tx_push_i;
  assign q_pop[Q_TX]   = eng_tx_pop_i;
  assign q_wdata[Q_TX] = host_tx_data_i;
  assign q_flush[Q_TX] = flush_all || slv_bulk_abort_i;

  assign q_push[Q_RX]  = eng_rx_push_i;
  assign q_pop[Q_RX]   = host_rx_pop_i;
  assign q_wdata[Q_RX] = eng_rx_data_i;
  assign q_flush[Q_RX] = flush_all;

  for (genvar g = 0; g < NUM_QUEUES; g++) begin : g_queue
    i2c_fst_fifo #(
      .DEPTH (DEPTH),
      .WIDTH (WIDTH)
    ) u_fifo (
      .clk       (clk),
      .rst_n     (rst_n_int),
      .flush     (q_flush[g]),
      .push      (q_push[g]),
      .push_data (q_wdata[g]),
      .pop       (q_pop[g]),
      .pop_data  (q_rdata[g]),
      .level     (q_lvl[g])
    );
  end

  assign eng_tx_data_o  = q_rdata[Q_TX];
  assign host_rx_data_o = q_rdata[Q_RX];

  fst_flags_t flags;

  i2c_fst_flags #(
    .DEPTH (DEPTH)
  ) u_flags (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .tx_lvl (q_lvl[Q_TX]),
    .rx_lvl (q_lvl[Q_RX]),
    .flags  (flags)
  );

  logic              abrt_rd;
  logic              abrt_clr;
  logic [NCAUSE-1:0] abrt_src;

  assign abrt_rd  = reg_rd_en_i && (reg_addr_i == OFS_ABRT);
  assign abrt_clr = abrt_rd || intr_clr_all_i;

  i2c_fst_abrt #(
    .NCAUSE (NCAUSE)
  ) u_abrt (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .set_en (tx_abort_i),
    .cause  (abrt_cause_i),
    .clr    (abrt_clr),
    .src    (abrt_src)
  );

  logic [REG_DW-1:0] rdata_d, rdata_q;
  logic [3:0]        status_word;

  assign status_word = {flags.rx_nempty, flags.tx_empty, flags.tx_nfull, 1'b0};

  always_comb begin
    rdata_d = '0;
    if (reg_rd_en_i) begin
      unique case (reg_addr_i)
        OFS_STATUS: rdata_d = REG_DW'(status_word);
        OFS_TXLVL:  rdata_d = REG_DW'(q_lvl[Q_TX]);
        OFS_RXLVL:  rdata_d = REG_DW'(q_lvl[Q_RX]);
        OFS_ABRT:   rdata_d = REG_DW'(abrt_src);
        default:    rdata_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) rdata_q <= '0;
    else            rdata_q <= rdata_d;
  end

  assign reg_rdata_o = rdata_q;

  AST_RD_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n_int)
    !reg_rd_en_i |=> (reg_rdata_o == '0)); // R11
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n_int)
    (abrt_rd && !tx_abort_i) |=> (abrt_src == '0)); // R10
  AST_BULK_KEEPS_RX: assert property (@(posedge clk) disable iff (!rst_n_int)
    (slv_bulk_abort_i && ctrl_en_i && !tx_abort_i && !eng_rx_push_i && !host_rx_pop_i)
    |=> $stable(q_lvl[Q_RX])); // R4

endmodule

// File: tb/i2c_fifo_tracker_tb.sv
`timescale 1ns/1ps
module i2c_fifo_tracker_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctrl_en_i = 1'b1;
  logic        tx_abort_i = 1'b0;
  logic [15:0] abrt_cause_i = '0;
  logic        slv_bulk_abort_i = 1'b0;
  logic        intr_clr_all_i = 1'b0;
  logic        host_tx_push_i = 1'b0;
  logic [7:0]  host_tx_data_i = '0;
  logic        host_rx_pop_i = 1'b0;
  logic [7:0]  host_rx_data_o;
  logic        eng_tx_pop_i = 1'b0;
  logic [7:0]  eng_tx_data_o;
  logic        eng_rx_push_i = 1'b0;
  logic [7:0]  eng_rx_data_i = '0;
  logic        reg_rd_en_i = 1'b0;
  logic [7:0]  reg_addr_i = '0;
  logic [31:0] reg_rdata_o;

  always #2 clk = ~clk;

  i2c_fifo_tracker dut_i (.*);

  int tests = 0;
  int fails = 0;
  bit done = 0;
  string phase = "";
  bit hold_addr = 0;
  int rot = 0;

  logic [7:0]  txq[$];
  logic [7:0]  rxq[$];
  logic        m_rxne = 1'b0, m_txe = 1'b1, m_txnf = 1'b1;
  logic [15:0] m_abrt = '0;

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL [%s] %s: got %h exp %h", phase, tag, got, exp);
    end
  endtask

  function automatic logic [7:0] rot_addr(input int r);
    case (r)
      0: return 8'h00;
      1: return 8'h04;
      2: return 8'h08;
      3: return 8'h0C;
      default: return 8'h10;
    endcase
  endfunction

  task automatic cyc();
    logic [31:0] exp_rd;
    string tag;
    int tsz, rsz;
    bit txf, rxf, tpop, tpush, rpop, rpush, clr;
    if (!hold_addr) begin
      reg_rd_en_i = 1'b1;
      reg_addr_i  = rot_addr(rot);
      rot = (rot + 1) % 5;
    end
    #1;
    tsz = txq.size();
    rsz = rxq.size();
    txf = !ctrl_en_i || tx_abort_i || slv_bulk_abort_i;
    rxf = !ctrl_en_i || tx_abort_i;
    rpop = host_rx_pop_i && rsz > 0 && !rxf;
    tpop = eng_tx_pop_i && tsz > 0 && !txf;
    if (rpop) check("R9 rx order", {24'h0, host_rx_data_o}, {24'h0, rxq[0]});
    if (tpop) check("R9 tx order", {24'h0, eng_tx_data_o}, {24'h0, txq[0]});
    exp_rd = '0;
    tag = "R11 idle/unmapped";
    if (reg_rd_en_i) begin
      case (reg_addr_i)
        8'h00: begin exp_rd = {28'h0, m_rxne, m_txe, m_txnf, 1'b0}; tag = "R5 R6 R7 status"; end
        8'h04: begin exp_rd = 32'(tsz); tag = "R1 tx level"; end
        8'h08: begin exp_rd = 32'(rsz); tag = "R1 rx level"; end
        8'h0C: begin exp_rd = {16'h0, m_abrt}; tag = "R10 abort source"; end
        default: ;
      endcase
    end
    m_rxne = (rsz != 0);
    m_txe  = (tsz == 0);
    m_txnf = (tsz != 8);
    tpush = host_tx_push_i && !txf && (tsz < 8 || tpop);
    rpush = eng_rx_push_i && !rxf && (rsz < 8 || rpop);
    if (txf) txq.delete();
    else begin
      if (tpop) void'(txq.pop_front());
      if (tpush) txq.push_back(host_tx_data_i);
    end
    if (rxf) rxq.delete();
    else begin
      if (rpop) void'(rxq.pop_front());
      if (rpush) rxq.push_back(eng_rx_data_i);
    end
    clr = intr_clr_all_i || (reg_rd_en_i && reg_addr_i == 8'h0C);
    if (clr) m_abrt = '0;
    else if (tx_abort_i) m_abrt = m_abrt | abrt_cause_i;
    @(posedge clk);
    @(negedge clk);
    check(tag, reg_rdata_o, exp_rd);
  endtask

  task automatic read_reg(input logic [7:0] a);
    hold_addr = 1;
    reg_rd_en_i = 1'b1;
    reg_addr_i = a;
    cyc();
    hold_addr = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    phase = "R2 reset";
    repeat (6) cyc();

    phase = "R1 R8 tx overfill";
    host_tx_push_i = 1;
    for (int i = 0; i < 11; i++) begin host_tx_data_i = 8'(8'h10 + i); cyc(); end
    host_tx_push_i = 0;
    repeat (5) cyc();

    phase = "R8 R9 tx drain";
    eng_tx_pop_i = 1;
    repeat (11) cyc();
    eng_tx_pop_i = 0;
    repeat (5) cyc();

    phase = "R9 push and pop together";
    host_tx_push_i = 1;
    for (int i = 0; i < 3; i++) begin host_tx_data_i = 8'(8'h40 + i); cyc(); end
    eng_tx_pop_i = 1;
    for (int i = 0; i < 6; i++) begin host_tx_data_i = 8'(8'h50 + i); cyc(); end
    eng_tx_pop_i = 0;
    for (int i = 0; i < 6; i++) begin host_tx_data_i = 8'(8'h60 + i); cyc(); end
    eng_tx_pop_i = 1;
    for (int i = 0; i < 5; i++) begin host_tx_data_i = 8'(8'h70 + i); cyc(); end
    host_tx_push_i = 0;
    repeat (10) cyc();
    host_tx_push_i = 1;
    for (int i = 0; i < 2; i++) begin host_tx_data_i = 8'(8'h80 + i); cyc(); end
    host_tx_push_i = 0; eng_tx_pop_i = 0;
    repeat (5) cyc();

    phase = "R1 R5 rx fill";
    eng_rx_push_i = 1;
    for (int i = 0; i < 9; i++) begin eng_rx_data_i = 8'(8'hA0 + i); cyc(); end
    eng_rx_push_i = 0;
    host_rx_pop_i = 1;
    repeat (3) cyc();
    host_rx_pop_i = 0;
    repeat (5) cyc();

    phase = "R4 bulk abort";
    host_tx_push_i = 1;
    for (int i = 0; i < 4; i++) begin host_tx_data_i = 8'(8'hB0 + i); cyc(); end
    slv_bulk_abort_i = 1;
    cyc();
    slv_bulk_abort_i = 0; host_tx_push_i = 0;
    repeat (5) cyc();

    phase = "R3 R10 transmit abort";
    host_tx_push_i = 1; eng_rx_push_i = 1;
    tx_abort_i = 1; abrt_cause_i = 16'h0005;
    cyc();
    tx_abort_i = 0; abrt_cause_i = '0; host_tx_push_i = 0; eng_rx_push_i = 0;
    repeat (5) cyc();
    tx_abort_i = 1; abrt_cause_i = 16'h0100; cyc();
    abrt_cause_i = 16'h0020; cyc();
    tx_abort_i = 0; abrt_cause_i = '0;
    read_reg(8'h0C);
    read_reg(8'h0C);
    tx_abort_i = 1; abrt_cause_i = 16'h0003; cyc();
    abrt_cause_i = 16'hFFFF; intr_clr_all_i = 1; cyc();
    tx_abort_i = 0; abrt_cause_i = '0; intr_clr_all_i = 0;
    read_reg(8'h0C);
    tx_abort_i = 1; abrt_cause_i = 16'h8000; read_reg(8'h0C);
    tx_abort_i = 0; abrt_cause_i = '0;
    read_reg(8'h0C);

    phase = "R3 disable";
    host_tx_push_i = 1; eng_rx_push_i = 1;
    repeat (4) cyc();
    ctrl_en_i = 0;
    repeat (3) cyc();
    ctrl_en_i = 1; host_tx_push_i = 0; eng_rx_push_i = 0;
    repeat (5) cyc();

    phase = "R11 no strobe";
    hold_addr = 1; reg_rd_en_i = 0; reg_addr_i = 8'h04;
    repeat (3) cyc();
    hold_addr = 0;

    phase = "random traffic";
    for (int i = 0; i < 3000; i++) begin
      host_tx_push_i   = $urandom_range(0, 1) != 0;
      host_tx_data_i   = 8'($urandom);
      eng_tx_pop_i     = $urandom_range(0, 2) == 0;
      eng_rx_push_i    = $urandom_range(0, 1) != 0;
      eng_rx_data_i    = 8'($urandom);
      host_rx_pop_i    = $urandom_range(0, 2) == 0;
      tx_abort_i       = $urandom_range(0, 63) == 0;
      abrt_cause_i     = 16'($urandom);
      slv_bulk_abort_i = $urandom_range(0, 63) == 0;
      ctrl_en_i        = $urandom_range(0, 63) != 0;
      intr_clr_all_i   = $urandom_range(0, 31) == 0;
      cyc();
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL [watchdog] run did not complete: got hung exp done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule